// File: doc/BRIEF.md
# Accumulator Add/Subtract Flag Unit

This block performs 8-bit binary addition with carry and subtraction with borrow between an accumulator value and an operand byte, and keeps an 8-bit processor status byte whose carry, overflow, negative and zero bits follow each result. A subtraction adds the inverted operand plus the stored carry, so the carry bit behaves as an inverted borrow. Overflow is judged only against the signed limits -128..+127: a result that merely crosses zero, such as 0x40 minus 0x41 giving 0xFF, leaves overflow clear.

The surrounding datapath presents the accumulator and operand together with a strobe and an add/subtract select, and receives the new accumulator and status one clock later from registers. Software-visible status can be loaded through a separate write path. When that write and an arithmetic strobe arrive in the same cycle, the written byte is forwarded: its carry feeds the operation, and its non-arithmetic bits survive into the result.

Top module: `accflag_unit`

## Requirements
- R1: During and after synchronous reset, with no strobe, acc_out reads 0x00 and stat_out reads RESET_STATUS (default 0x24).
- R2: With op_valid=1 and op_sub=0, one clock later acc_out = (acc_in + operand_in + C) mod 256, where C is status bit 0, and bit 0 becomes 1 exactly when the unsigned sum exceeds 255.
- R3: With op_valid=1 and op_sub=1, one clock later acc_out = (acc_in - operand_in - (1 - C)) mod 256, and status bit 0 becomes 1 exactly when that difference is not negative (no borrow).
- R4: Status bit 6 (overflow) is set after an operation exactly when the signed result lies outside -128..+127; crossing zero alone never sets it, so operands of opposite effective sign never set it.
- R5: After an operation, status bit 7 equals bit 7 of the new acc_out and status bit 1 is set exactly when the new acc_out is 0x00.
- R6: Status bits 4..2 are unchanged by an operation, and status bit 5 reads 1 at all times.
- R7: With stat_wr=1 and op_valid=0, one clock later stat_out = stat_wdata with bit 5 forced to 1, and acc_out is unchanged.
- R8: With stat_wr=1 and op_valid=1 in the same cycle, the operation uses bit 0 of stat_wdata as its carry in, and the resulting status takes bits 5..2 from stat_wdata (bit 5 forced to 1) and bits 7, 6, 1, 0 from the operation.
- R9: With neither op_valid nor stat_wr, acc_out and stat_out hold their values.
- R10: Starting from status 0xE5, a subtraction of 0x41 from 0x40 yields acc_out 0xFF and stat_out 0xA4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: perform an operation this cycle |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| acc_in | input | DW | Accumulator value entering the operation |
| operand_in | input | DW | Operand byte |
| stat_wr | input | 1 | Load the status byte from stat_wdata |
| stat_wdata | input | 8 | Status byte to load |
| acc_out | output | DW | Registered result accumulator |
| stat_out | output | 8 | Registered status byte (N7 V6 1 B4 D3 I2 Z1 C0) |

## Verification
The status write and an arithmetic strobe can land in the same cycle, which makes the forwarding path the most delicate point of the unit. The random stimulus asserts both together in part of its cycles, often with a written carry that differs from the stored one and with the pass-through bits changed, and a directed case writes a known decimal-and-carry pattern alongside an addition. The expected byte is built from the written value and from signed and unsigned integer arithmetic in the bench, so a design that used the stale carry or dropped the written upper bits is caught.

// File: rtl/accflag_pkg.sv
package accflag_pkg;
  // Status bit positions; the consumer decodes these, so they are fixed.
  localparam int SB_C   = 0;
  localparam int SB_Z   = 1;
  localparam int SB_I   = 2;
  localparam int SB_D   = 3;
  localparam int SB_B   = 4;
  localparam int SB_ONE = 5;
  localparam int SB_V   = 6;
  localparam int SB_N   = 7;
  localparam int SW     = 8;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
    logic carry;
  } arith_flags_t;
endpackage

// File: rtl/accflag_adder.sv
module accflag_adder
  import accflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   m,
  input  logic            cin,
  output logic [DW-1:0]   b_eff,
  output logic [DW-1:0]   res,
  output logic            cout
);
  localparam int SUMW = DW + 1;

  logic [SUMW-1:0] sum;

  // Subtraction reuses the adder: the operand is inverted bit by bit.
  for (genvar i = 0; i < DW; i++) begin : g_cond
    assign b_eff[i] = m[i] ^ (op == OP_SUB);
  end

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    res  = sum[DW-1:0];
    cout = sum[SUMW-1];
  end
endmodule

// File: rtl/accflag_flags.sv
module accflag_flags
  import accflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b_eff,
  input  logic [DW-1:0] res,
  input  logic          cout,
  output arith_flags_t  fl
);
  localparam int MSB = DW - 1;

  always_comb begin
    fl.neg   = res[MSB];
    // Signed overflow: both addends share a sign and the result does not.
    fl.ovf   = (a[MSB] == b_eff[MSB]) && (res[MSB] != a[MSB]);
    fl.zero  = (res == '0);
    fl.carry = cout;
  end
endmodule

// File: rtl/accflag_status.sv
module accflag_status
  import accflag_pkg::*;
#(
  parameter logic [SW-1:0] RESET_STATUS = 8'h24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [SW-1:0] wdata,
  input  logic          upd,
  input  arith_flags_t  fl,
  output logic          cin,
  output logic [SW-1:0] st
);
  logic [SW-1:0] st_q;
  logic [SW-1:0] base;
  logic [SW-1:0] st_d;

  always_comb begin
    // A same-cycle write is forwarded into the operation.
    base         = wr ? wdata : st_q;
    base[SB_ONE] = 1'b1;
    cin          = base[SB_C];
    st_d         = base;
    if (upd) begin
      st_d[SB_N] = fl.neg;
      st_d[SB_V] = fl.ovf;
      st_d[SB_Z] = fl.zero;
      st_d[SB_C] = fl.carry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= RESET_STATUS | (SW'(1) << SB_ONE);
    else     st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/accflag_unit.sv
module accflag_unit
  import accflag_pkg::*;
#(
  parameter int             DW           = 8,
  parameter logic [SW-1:0]  RESET_STATUS = 8'h24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_sub,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] operand_in,
  input  logic          stat_wr,
  input  logic [SW-1:0] stat_wdata,
  output logic [DW-1:0] acc_out,
  output logic [SW-1:0] stat_out
);
  alu_op_e       op;
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [DW-1:0] res;
  logic          cout;
  arith_flags_t  fl;
  logic [DW-1:0] acc_q;

  assign op = alu_op_e'(op_sub);

  accflag_adder #(.DW(DW)) u_add (
    .op    (op),
    .a     (acc_in),
    .m     (operand_in),
    .cin   (cin),
    .b_eff (b_eff),
    .res   (res),
    .cout  (cout)
  );

  accflag_flags #(.DW(DW)) u_flg (
    .a     (acc_in),
    .b_eff (b_eff),
    .res   (res),
    .cout  (cout),
    .fl    (fl)
  );

  accflag_status #(.RESET_STATUS(RESET_STATUS)) u_st (
    .clk   (clk),
    .rst   (rst),
    .wr    (stat_wr),
    .wdata (stat_wdata),
    .upd   (op_valid),
    .fl    (fl),
    .cin   (cin),
    .st    (stat_out)
  );

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (op_valid) acc_q <= res;
  end

  assign acc_out = acc_q;
endmodule

// File: rtl/accflag_chk.sv
module accflag_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          op_sub,
  input logic [DW-1:0] acc_in,
  input logic [DW-1:0] operand_in,
  input logic          stat_wr,
  input logic [7:0]    stat_wdata,
  input logic [DW-1:0] acc_out,
  input logic [7:0]    stat_out
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !stat_wr) |=> ($stable(acc_out) && $stable(stat_out)));

  p_one_bit_r6: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> stat_out[5]);

  p_passthru_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !stat_wr) |=> (stat_out[4:2] == $past(stat_out[4:2])));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (stat_out[1] == (acc_out == '0)));

  p_neg_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (stat_out[7] == acc_out[DW-1]));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ((operand_in[DW-1] ^ op_sub) != acc_in[DW-1])) |=> !stat_out[6]);

  p_write_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !op_valid) |=> (stat_out == ($past(stat_wdata) | 8'h20)));

  p_write_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !op_valid) |=> $stable(acc_out));

  p_fwd_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && op_valid) |=> (stat_out[4:2] == $past(stat_wdata[4:2])));

  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_sub && !stat_wr) |=>
      (acc_out == DW'($past(acc_in) + $past(operand_in) + DW'($past(stat_out[0])))));
endmodule

bind accflag_unit accflag_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_sub     (op_sub),
  .acc_in     (acc_in),
  .operand_in (operand_in),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .acc_out    (acc_out),
  .stat_out   (stat_out)
);

// File: tb/accflag_unit_test.sv
module accflag_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       op_sub = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] operand_in = 8'h00;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic [7:0] acc_out;
  logic [7:0] stat_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_acc = 8'h00;
  logic [7:0] exp_st  = 8'h24;
  bit finished = 0;

  always #2 clk = ~clk;

  accflag_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub),
    .acc_in(acc_in), .operand_in(operand_in), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .acc_out(acc_out), .stat_out(stat_out)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive one cycle, compute expectations from integer arithmetic, then compare.
  task automatic step(input bit v, input bit s, input logic [7:0] a, input logic [7:0] m,
                      input bit w, input logic [7:0] wd);
    logic [7:0] base;
    logic [7:0] res;
    bit cin, c, ov;
    int tot, sv;
    string rq;
    @(negedge clk);
    op_valid = v; op_sub = s; acc_in = a; operand_in = m;
    stat_wr = w; stat_wdata = wd;
    base = w ? (wd | 8'h20) : exp_st;
    cin = base[0];
    if (v) begin
      if (!s) begin
        tot = int'(a) + int'(m) + int'(cin);
        c   = (tot > 255);
        sv  = int'($signed(a)) + int'($signed(m)) + int'(cin);
      end else begin
        tot = int'(a) - int'(m) - (1 - int'(cin));
        c   = (tot >= 0);
        sv  = int'($signed(a)) - int'($signed(m)) - (1 - int'(cin));
      end
      res = 8'(tot);
      ov  = (sv > 127) || (sv < -128);
      exp_acc = res;
      exp_st  = {res[7], ov, base[5:2], res == 8'h00, c};
    end else begin
      exp_st = base;
    end
    @(posedge clk);
    #1;
    rq = !v ? (w ? "R7" : "R9") : (s ? "R3" : "R2");
    chk(acc_out == exp_acc, {rq, " acc"}, acc_out, exp_acc);
    chk(stat_out[0] == exp_st[0], {rq, " carry"}, stat_out, exp_st);
    if (v) begin
      chk(stat_out[6] == exp_st[6], "R4 overflow", stat_out, exp_st);
      chk(stat_out[7] == exp_st[7] && stat_out[1] == exp_st[1], "R5 neg/zero", stat_out, exp_st);
      chk(stat_out[5:2] == exp_st[5:2], w ? "R8 forwarded bits" : "R6 pass-through", stat_out, exp_st);
    end else begin
      chk(stat_out == exp_st, {rq, " status"}, stat_out, exp_st);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0617));
    repeat (3) @(posedge clk);
    #1;
    chk(acc_out == 8'h00, "R1 reset acc", acc_out, 8'h00);
    chk(stat_out == 8'h24, "R1 reset status", stat_out, 8'h24);
    @(negedge clk);
    rst = 1'b0;

    // R10: worked subtraction from status 0xE5
    step(0, 0, 8'h00, 8'h00, 1, 8'hE5);
    step(1, 1, 8'h40, 8'h41, 0, 8'h00);
    chk(acc_out == 8'hFF, "R10 acc", acc_out, 8'hFF);
    chk(stat_out == 8'hA4, "R10 status", stat_out, 8'hA4);
    chk(stat_out[6] == 1'b0, "R4 zero crossing", stat_out, 8'hA4);
    // R4: positive + positive leaves signed range
    step(0, 0, 8'h00, 8'h00, 1, 8'h00);
    step(1, 0, 8'h7F, 8'h01, 0, 8'h00);
    chk(stat_out[6] == 1'b1, "R4 add overflow", stat_out, 8'hE0);
    // R4: -128 - 1 leaves signed range
    step(0, 0, 8'h00, 8'h00, 1, 8'h01);
    step(1, 1, 8'h80, 8'h01, 0, 8'h00);
    chk(stat_out[6] == 1'b1 && acc_out == 8'h7F, "R4 sub overflow", stat_out, 8'h61);
    // R5: wrap to zero with carry out
    step(0, 0, 8'h00, 8'h00, 1, 8'h00);
    step(1, 0, 8'hFF, 8'h01, 0, 8'h00);
    chk(stat_out == 8'h23 && acc_out == 8'h00, "R5 zero and carry", stat_out, 8'h23);
    // R7: bit 5 forced on write
    step(0, 0, 8'h55, 8'h00, 1, 8'h00);
    chk(stat_out == 8'h20, "R7 bit5 forced", stat_out, 8'h20);
    // R8: same-cycle write supplies carry and decimal bit
    step(1, 0, 8'h10, 8'h20, 1, 8'h09);
    chk(acc_out == 8'h31 && stat_out == 8'h28, "R8 forward", stat_out, 8'h28);
    // R9: idle hold
    step(0, 1, 8'hAA, 8'hBB, 0, 8'hFF);
    step(0, 0, 8'h01, 8'h02, 0, 8'h00);

    for (int i = 0; i < 500; i++) begin
      automatic bit v = ($urandom % 10) < 7;
      automatic bit w = ($urandom % 10) < 2;
      step(v, 1'($urandom), 8'($urandom), 8'($urandom), w, 8'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule